// File: doc/BRIEF.md
# Coarse Frequency Calibration Loop

This block brings a switched-capacitor oscillator close to its target frequency before an analog fine-tuning loop takes over. It counts oscillator cycles inside windows one reference period long, compares each count with an 8-bit ratio, and moves a 32-bit capacitor bank code by one step per decision. When the count equals the ratio, it raises a lock flag that hands control to the analog loop. The block never stops calibrating: after every decision it goes back to measuring, so it follows a changed ratio or a drifting oscillator without a new reset.

The oscillator cycles are counted by a free-running binary counter in the oscillator domain. The counter is published as a Gray code and passes through a two-flop synchroniser into the reference domain. A window's count is the difference between two synchronised samples taken one reference period apart. All state and outputs are clocked by the reference clock. The bank code is a thermometer code filled from bit 0. More set bits means more capacitance, and so a lower frequency.

Top module: `coarse_cal_fll`

## Requirements
- R1: While rst_ni is low, bank_o holds the preset 32'h0000_FFFF (sixteen ones in bits 15:0) and lock_o is 0.
- R2: bank_o is always a thermometer code: its set bits are contiguous and start at bit 0.
- R3: If a window counts fewer oscillator rising edges than ratio_i, one decision clears the highest set bit of bank_o (the code shifts right by one), which raises the frequency.
- R4: If a window counts more edges than ratio_i, one decision sets the lowest clear bit of bank_o (the code shifts left by one, with a 1 shifted in at bit 0), which lowers the frequency.
- R5: lock_o is updated only at a decision. It becomes 1 when the count equals ratio_i and 0 otherwise, and bank_o does not change while the count matches.
- R6: The code saturates at all zeros and at all ones without wrapping. For a ratio that cannot be reached, lock_o stays 0.
- R7: A bank change is followed by SETTLE_CYC (default 3) settling reference cycles, one counting cycle and one decision cycle. Two bank changes are therefore at least 5 reference cycles apart, and a run of consecutive steps is exactly 5 cycles apart.
- R8: Calibration runs continuously. After lock, a new ratio_i makes the loop leave lock and settle on the new matching code without reset. Any reachable code is found within 32 decisions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Reference clock; defines the window and clocks all decisions |
| osc_clk_i | input | 1 | Oscillator clock being calibrated |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| ratio_i | input | 8 | Target oscillator cycles per reference period |
| bank_o | output | 32 | Thermometer capacitor bank code |
| lock_o | output | 1 | Count matched ratio at the last decision |

## Verification
The assertions check on every cycle that the bank stays a thermometer code, changes by exactly one bit and only right after a decision, stays put at saturation, and holds while a match is declared. They also check that the decision state always exits and that the Gray count moves one bit per oscillator edge. Only the bench scenarios can show the closed-loop behaviour, using an oscillator model whose count per window is 40 minus the number of set bank bits. These scenarios cover convergence to the right code in both directions, relock after a ratio change, saturation for unreachable ratios, and the 5-cycle spacing of consecutive steps.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic [1:0] {ST_SETTLE, ST_COUNT, ST_DECIDE} cal_state_e;
  // DIR_UP raises frequency (fewer ones), DIR_DOWN lowers it
  typedef enum logic [1:0] {DIR_HOLD, DIR_UP, DIR_DOWN} step_dir_e;
endpackage

// File: rtl/cal_osc_count.sv
module cal_osc_count #(
  parameter int CNT_W = 10
) (
  input  logic             osc_clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] gray_o
);
  logic [CNT_W-1:0] bin_q;
  logic [CNT_W-1:0] bin_nxt;

  assign bin_nxt = bin_q + CNT_W'(1);

  always_ff @(posedge osc_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_o <= '0;
    end else begin
      bin_q  <= bin_nxt;
      gray_o <= bin_nxt ^ (bin_nxt >> 1);
    end
  end

  AST_GRAY_ONE_BIT: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    $countones(gray_o ^ $past(gray_o)) == 1 || $past(bin_q) == bin_q) // R3
    else $error("gray count moved more than one bit");
endmodule

// File: rtl/cal_sync.sv
module cal_sync #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/cal_bank_step.sv
module cal_bank_step
  import cal_pkg::*;
#(
  parameter int BANK_W = 32
) (
  input  logic [BANK_W-1:0] bank_i,
  input  step_dir_e         dir_i,
  output logic [BANK_W-1:0] bank_o
);
  always_comb begin
    case (dir_i)
      DIR_UP:   bank_o = bank_i >> 1;
      DIR_DOWN: bank_o = {bank_i[BANK_W-2:0], 1'b1};
      default:  bank_o = bank_i;
    endcase
  end
endmodule

// File: rtl/cal_fsm.sv
module cal_fsm
  import cal_pkg::*;
#(
  parameter int                CNT_W       = 10,
  parameter int                RATIO_W     = 8,
  parameter int                BANK_W      = 32,
  parameter int                SETTLE_CYC  = 3,
  parameter logic [BANK_W-1:0] BANK_PRESET = '0
) (
  input  logic               ref_clk_i,
  input  logic               rst_ni,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic [BANK_W-1:0]  bank_o,
  output logic               lock_o
);
  localparam int SET_W = $clog2(SETTLE_CYC + 1);
  localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CYC - 1);

  cal_state_e        state_q;
  logic [SET_W-1:0]  settle_q;
  logic [CNT_W-1:0]  start_q;
  logic [CNT_W-1:0]  meas_q;
  logic [BANK_W-1:0] bank_q;
  logic [BANK_W-1:0] bank_nxt;
  logic              lock_q;
  logic [CNT_W-1:0]  ratio_ext;
  step_dir_e         dir;

  assign ratio_ext = CNT_W'(ratio_i);

  always_comb begin
    dir = DIR_HOLD;
    if (state_q == ST_DECIDE) begin
      if (meas_q < ratio_ext)      dir = DIR_UP;
      else if (meas_q > ratio_ext) dir = DIR_DOWN;
    end
  end

  cal_bank_step #(.BANK_W(BANK_W)) u_step (
    .bank_i(bank_q),
    .dir_i (dir),
    .bank_o(bank_nxt)
  );

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_SETTLE;
      settle_q <= '0;
      start_q  <= '0;
      meas_q   <= '0;
      bank_q   <= BANK_PRESET;
      lock_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_SETTLE: begin
          if (settle_q == SET_LAST) begin
            state_q <= ST_COUNT;
            start_q <= cnt_i;
          end else begin
            settle_q <= settle_q + SET_W'(1);
          end
        end
        ST_COUNT: begin
          meas_q  <= cnt_i - start_q;
          state_q <= ST_DECIDE;
        end
        ST_DECIDE: begin
          bank_q <= bank_nxt;
          lock_q <= (meas_q == ratio_ext);
          if (bank_nxt != bank_q) begin
            state_q  <= ST_SETTLE;
            settle_q <= '0;
          end else begin
            state_q <= ST_COUNT;
            start_q <= cnt_i;
          end
        end
        default: begin
          state_q  <= ST_SETTLE;
          settle_q <= '0;
        end
      endcase
    end
  end

  assign bank_o = bank_q;
  assign lock_o = lock_q;

  AST_BANK_THERMO: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    ((bank_q + BANK_W'(1)) & bank_q) == '0) // R2
    else $error("bank not thermometer");
  AST_ONE_STEP: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (bank_q != $past(bank_q)) |-> ($countones(bank_q ^ $past(bank_q)) == 1)) // R3
    else $error("bank moved more than one step");
  AST_CHANGE_AFTER_DECIDE: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (bank_q != $past(bank_q)) |-> ($past(state_q) == ST_DECIDE)) // R7
    else $error("bank changed outside a decision");
  AST_LOCK_HOLDS_BANK: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (state_q == ST_DECIDE && meas_q == ratio_ext) |=> ($stable(bank_q) && lock_q)) // R5
    else $error("matched count moved bank or missed lock");
  AST_LOCK_ONLY_DECIDE: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (state_q != ST_DECIDE) |=> $stable(lock_q)) // R5
    else $error("lock changed outside a decision");
  AST_SAT_FULL: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (state_q == ST_DECIDE && &bank_q && meas_q > ratio_ext) |=> (&bank_q)) // R6
    else $error("bank wrapped past all ones");
  AST_SAT_EMPTY: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (state_q == ST_DECIDE && bank_q == '0 && meas_q < ratio_ext) |=> (bank_q == '0)) // R6
    else $error("bank wrapped past all zeros");
  AST_DECIDE_EXITS: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (state_q == ST_DECIDE) |=> (state_q != ST_DECIDE)) // R8
    else $error("decision state did not return to measuring");
endmodule

// File: rtl/coarse_cal_fll.sv
module coarse_cal_fll #(
  parameter int CNT_W      = 10,
  parameter int RATIO_W    = 8,
  parameter int BANK_W     = 32,
  parameter int SETTLE_CYC = 3
) (
  input  logic               ref_clk_i,
  input  logic               osc_clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic [BANK_W-1:0]  bank_o,
  output logic               lock_o
);
  // half the bank populated: nominal centre frequency
  localparam logic [BANK_W-1:0] BANK_PRESET = {BANK_W{1'b1}} >> (BANK_W / 2);

  logic [CNT_W-1:0] gray_osc;
  logic [CNT_W-1:0] gray_ref;
  logic [CNT_W-1:0] cnt_ref;

  cal_osc_count #(.CNT_W(CNT_W)) u_cnt (
    .osc_clk_i(osc_clk_i),
    .rst_ni   (rst_ni),
    .gray_o   (gray_osc)
  );

  cal_sync #(.W(CNT_W)) u_sync (
    .clk_i (ref_clk_i),
    .rst_ni(rst_ni),
    .d_i   (gray_osc),
    .q_o   (gray_ref)
  );

  always_comb begin
    cnt_ref[CNT_W-1] = gray_ref[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) cnt_ref[i] = cnt_ref[i+1] ^ gray_ref[i];
  end

  cal_fsm #(
    .CNT_W      (CNT_W),
    .RATIO_W    (RATIO_W),
    .BANK_W     (BANK_W),
    .SETTLE_CYC (SETTLE_CYC),
    .BANK_PRESET(BANK_PRESET)
  ) u_fsm (
    .ref_clk_i(ref_clk_i),
    .rst_ni   (rst_ni),
    .cnt_i    (cnt_ref),
    .ratio_i  (ratio_i),
    .bank_o   (bank_o),
    .lock_o   (lock_o)
  );
endmodule

// File: tb/tb_coarse_cal_fll.sv
`timescale 1ns/1fs
module tb_coarse_cal_fll;
  logic        ref_clk = 1'b0;
  logic        osc_clk = 1'b0;
  logic        rst_n   = 1'b1;
  logic [7:0]  ratio   = 8'd24;
  logic [31:0] bank;
  logic        lock;

  int n_cmp = 0;
  int n_bad = 0;
  int gap = 0;
  int min_gap = 1000;
  int gap_viol = 0;
  bit have_prev = 1'b0;
  logic [31:0] prev_bank = '0;

  coarse_cal_fll dut (
    .ref_clk_i(ref_clk),
    .osc_clk_i(osc_clk),
    .rst_ni   (rst_n),
    .ratio_i  (ratio),
    .bank_o   (bank),
    .lock_o   (lock)
  );

  always #5 ref_clk = ~ref_clk;

  // oscillator model: cycles per 10 ns window = 40 - set bits of bank
  initial begin
    #2.0317;
    forever begin
      #(5.0 / real'(40 - $countones(bank)));
      osc_clk = ~osc_clk;
    end
  end

  // step spacing monitor (R7)
  always @(negedge ref_clk) begin
    if (!rst_n) begin
      gap = 0;
      have_prev = 1'b0;
      prev_bank = bank;
    end else begin
      gap++;
      if (bank !== prev_bank) begin
        if (have_prev) begin
          if (gap < 5) gap_viol++;
          if (gap < min_gap) min_gap = gap;
        end
        have_prev = 1'b1;
        gap = 0;
        prev_bank = bank;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] thermo(input int ones);
    return 32'((64'd1 << ones) - 64'd1);
  endfunction

  task automatic wait_lock(output bit seen);
    seen = 1'b0;
    repeat (8) @(negedge ref_clk);
    for (int w = 0; w < 250; w++) begin
      @(negedge ref_clk);
      if (lock) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge ref_clk);
    chk("R1 bank preset", 64'(bank), 64'h0000_FFFF);
    chk("R1 lock low", 64'(lock), 64'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_match();
    bit seen;
    ratio = 8'd24;
    wait_lock(seen);
    chk("R5 lock at preset", 64'(seen), 64'd1);
    chk("R5 bank unchanged", 64'(bank), 64'h0000_FFFF);
    repeat (30) @(negedge ref_clk);
    chk("R5 bank holds while locked", 64'(bank), 64'h0000_FFFF);
    chk("R5 lock holds", 64'(lock), 64'd1);
  endtask

  task automatic t_seek(input string req, input logic [7:0] r);
    bit seen;
    ratio = r;
    wait_lock(seen);
    chk({req, " lock reached"}, 64'(seen), 64'd1);
    chk({req, " bank code"}, 64'(bank), 64'(thermo(40 - int'(r))));
    chk("R2 thermometer shape", 64'((bank + 32'd1) & bank), 64'd0);
  endtask

  task automatic t_sat(input logic [7:0] r, input logic [31:0] exp);
    ratio = r;
    repeat (260) @(negedge ref_clk);
    chk("R6 saturated code", 64'(bank), 64'(exp));
    chk("R6 lock stays low", 64'(lock), 64'd0);
    repeat (25) @(negedge ref_clk);
    chk("R6 no wrap", 64'(bank), 64'(exp));
  endtask

  initial begin
    #1 rst_n = 1'b0;
    t_reset();
    t_match();
    t_seek("R3", 8'd30);
    t_seek("R4", 8'd12);
    t_seek("R8 relock", 8'd26);
    t_sat(8'd200, 32'h0000_0000);
    t_sat(8'd3, 32'hFFFF_FFFF);
    t_seek("R8 recover", 8'd24);
    chk("R7 no close steps", 64'(gap_viol), 64'd0);
    chk("R7 step spacing", 64'(min_gap), 64'd5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule